// File: doc/BRIEF.md
# Byte-Order Selectable Data Packer

This block sits between a 16-bit host register port and a byte-wide serial engine. On the transmit side the host pushes halfwords, or a single trailing byte, into a small byte buffer, and the engine pulls bytes out one at a time, oldest first. On the receive side the engine deposits bytes one at a time, and the host collects them two at a time as a halfword. One control input chooses which half of the 16-bit word carries the earlier byte, in both directions.

The block keeps a fill count for each direction and maintains five sticky status flags: transmit ready, receive ready, single-byte data, receive overrun and transmit underflow. A write-one-to-clear vector lets the owner of those flags acknowledge them. When the host and the engine touch the same direction in one cycle, the block applies the engine's fetch before the host write, and the host read before the engine's receive.

Top module: `byte_order_packer`

## Requirements
- R1: After reset both fill counts, all five flags, `engTxByte` and `hostRdData` are zero.
- R2: A halfword write (`hostWrHalf`) is accepted only when the transmit count, taken after any same-cycle fetch, is at most DEPTH-2. An accepted halfword write adds 2 to the count. A refused write leaves the count and the buffer unchanged. `hostWrByte` is ignored in a cycle where `hostWrHalf` is high.
- R3: With `bigEndian`=1, byte `hostWrData[15:8]` of a halfword is sent before `hostWrData[7:0]`. With `bigEndian`=0, `hostWrData[7:0]` is sent first.
- R4: A byte write (`hostWrByte`) appends `hostWrData[7:0]` as the newest byte and adds 1 to the transmit count. It is refused under the same DEPTH-2 rule as R2.
- R5: `engTxByte` always shows the oldest queued byte, or zero when the queue is empty. `engTxTake` removes that byte. A take with an empty queue sets the underflow flag (bit 4) and changes nothing else.
- R6: An accepted host write clears the underflow flag. It also clears transmit ready (bit 0) if it leaves more than DEPTH-2 bytes queued. A take that leaves at most DEPTH-2 bytes queued sets transmit ready.
- R7: A received byte (`engRxValid`) is appended if fewer than DEPTH bytes are held, and then receive ready (bit 1) is set. Otherwise the byte is dropped and receive overrun (bit 3) is set.
- R8: `hostRdData` carries the two oldest received bytes. With `bigEndian`=1 the oldest byte is in bits [15:8]; with `bigEndian`=0 it is in bits [7:0]. A missing second byte reads as zero. With no bytes held, `hostRdData` is zero and a read (`hostRd`) changes nothing.
- R9: A read while one byte is held sets single-byte data (bit 2) and empties the buffer. A read while two or more bytes are held removes the two oldest bytes.
- R10: A read of a non-empty buffer clears receive overrun. A read that leaves the buffer empty clears receive ready.
- R11: In one cycle the fetch is applied before the host write, and the host read is applied before the receive. Each later step sees the count left by the earlier one.
- R12: A one in `flagClear` clears the flag at the same bit position. A flag set by an event in the same cycle stays set. Flag bit positions: 0 transmit ready, 1 receive ready, 2 single-byte data, 3 receive overrun, 4 transmit underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bigEndian | input | 1 | 1: earlier byte in bits [15:8] of host words |
| hostWrHalf | input | 1 | Host halfword write strobe |
| hostWrByte | input | 1 | Host single-byte write strobe |
| hostWrData | input | 16 | Host write data |
| hostRd | input | 1 | Host read strobe (consumes up to two bytes) |
| hostRdData | output | 16 | Two oldest received bytes, ordered by `bigEndian` |
| engTxTake | input | 1 | Engine removes the oldest transmit byte |
| engTxByte | output | 8 | Oldest transmit byte, zero when empty |
| engRxValid | input | 1 | Engine delivers a received byte |
| engRxByte | input | 8 | Received byte |
| flagClear | input | 5 | Write-one-to-clear for the flags |
| flags | output | 5 | Sticky status flags, positions as in R12 |
| txLen | output | LEN_W | Bytes queued for transmit |
| rxLen | output | LEN_W | Bytes held from receive |

## Verification
The bench builds the block with its default depth of four bytes. At that depth the refusal threshold of two bytes is reached after a single halfword write, so full-buffer refusals, overruns and the odd-count single-byte drain occur often under random traffic. A queue-based model in the bench tracks byte age directly rather than bit positions. It is driven with every same-cycle combination of fetch, write, read and receive, in both byte orders, with occasional flag clears.

// File: rtl/packer_pkg.sv
package packer_pkg;

  localparam int FLAG_W   = 5;
  localparam int FLAG_TXR = 0;
  localparam int FLAG_RXR = 1;
  localparam int FLAG_SBD = 2;
  localparam int FLAG_OVR = 3;
  localparam int FLAG_UDF = 4;

  typedef struct packed {
    logic txHalf;
    logic txByte;
    logic rxClear;
    logic rxDrop2;
    logic rxPut;
  } packer_strobe_t;

endpackage

// File: rtl/packer_ctrl.sv
module packer_ctrl
  import packer_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hostWrHalf,
  input  logic                  hostWrByte,
  input  logic                  hostRd,
  input  logic                  engTxTake,
  input  logic                  engRxValid,
  input  logic [FLAG_W-1:0]     flagClear,
  output packer_strobe_t        strobe,
  output logic [LEN_W-1:0]      rxPutPos,
  output logic [LEN_W-1:0]      txLen,
  output logic [LEN_W-1:0]      rxLen,
  output logic [FLAG_W-1:0]     flags
);

  localparam logic [LEN_W-1:0] LIM  = LEN_W'(DEPTH - 2);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO  = LEN_W'(2);

  logic [LEN_W-1:0]  txLenQ, txLenD, txMid;
  logic [LEN_W-1:0]  rxLenQ, rxLenD, rxMid;
  logic [FLAG_W-1:0] flagsQ, flagsD;

  always_comb begin
    strobe = '0;
    flagsD = flagsQ & ~flagClear;

    // transmit: engine fetch first, then host write
    txMid = txLenQ;
    if (engTxTake) begin
      if (txLenQ == '0) flagsD[FLAG_UDF] = 1'b1;
      else              txMid = txLenQ - ONE;
      if (txMid <= LIM) flagsD[FLAG_TXR] = 1'b1;
    end
    txLenD = txMid;
    if (txMid <= LIM) begin
      if (hostWrHalf) begin
        strobe.txHalf = 1'b1;
        txLenD = txMid + TWO;
      end else if (hostWrByte) begin
        strobe.txByte = 1'b1;
        txLenD = txMid + ONE;
      end
    end
    if (strobe.txHalf || strobe.txByte) begin
      flagsD[FLAG_UDF] = 1'b0;
      if (txLenD > LIM) flagsD[FLAG_TXR] = 1'b0;
    end

    // receive: host read first, then engine byte
    rxMid = rxLenQ;
    if (hostRd && rxLenQ != '0) begin
      flagsD[FLAG_OVR] = 1'b0;
      if (rxLenQ == ONE) flagsD[FLAG_SBD] = 1'b1;
      if (rxLenQ <= TWO) begin
        strobe.rxClear = 1'b1;
        rxMid = '0;
      end else begin
        strobe.rxDrop2 = 1'b1;
        rxMid = rxLenQ - TWO;
      end
      if (rxMid == '0) flagsD[FLAG_RXR] = 1'b0;
    end
    rxLenD   = rxMid;
    rxPutPos = rxMid;
    if (engRxValid) begin
      if (rxMid < FULL) begin
        strobe.rxPut = 1'b1;
        rxLenD = rxMid + ONE;
        flagsD[FLAG_RXR] = 1'b1;
      end else begin
        flagsD[FLAG_OVR] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txLenQ <= '0;
      rxLenQ <= '0;
      flagsQ <= '0;
    end else begin
      txLenQ <= txLenD;
      rxLenQ <= rxLenD;
      flagsQ <= flagsD;
    end
  end

  assign txLen = txLenQ;
  assign rxLen = rxLenQ;
  assign flags = flagsQ;

  // R2: halfword write against a full-enough queue is refused
  a_r2_half_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWrHalf && !engTxTake && txLenQ > LIM) |=> (txLenQ == $past(txLenQ)));

  // R5: lone fetch of a non-empty queue removes exactly one byte
  a_r5_fetch_one: assert property (@(posedge clk) disable iff (!rst_n)
    (engTxTake && !hostWrHalf && !hostWrByte && txLenQ != '0) |=> (txLenQ == $past(txLenQ) - ONE));

  // R7: counts never exceed the depth
  a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (txLenQ <= FULL) && (rxLenQ <= FULL));

  // R7: byte into a full buffer without a read raises overrun and keeps the count
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (engRxValid && !hostRd && rxLenQ == FULL) |=> (flagsQ[FLAG_OVR] && rxLenQ == FULL));

  // R9: draining a lone byte raises single-byte data and empties the buffer
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRd && !engRxValid && rxLenQ == ONE) |=> (flagsQ[FLAG_SBD] && rxLenQ == '0));

  // R10: a non-empty read clears overrun
  a_r10_read_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRd && rxLenQ != '0) |=> !flagsQ[FLAG_OVR]);

endmodule

// File: rtl/packer_data.sv
module packer_data
  import packer_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  packer_strobe_t   strobe,
  input  logic             bigEndian,
  input  logic [15:0]      wrData,
  input  logic [LEN_W-1:0] txLen,
  input  logic [LEN_W-1:0] rxLen,
  input  logic [LEN_W-1:0] rxPutPos,
  input  logic [7:0]       rxByte,
  output logic [7:0]       txByteOut,
  output logic [15:0]      rdData
);

  localparam int BUF_W = DEPTH * 8;

  logic [BUF_W-1:0] txBuf, txNext;
  logic [BUF_W-1:0] rxBuf, rxNext;
  logic [7:0]       firstByte, secondByte;
  logic [7:0]       rdOld, rdNew;

  // earlier-sent byte of a halfword lands above the later one
  assign firstByte  = bigEndian ? wrData[15:8] : wrData[7:0];
  assign secondByte = bigEndian ? wrData[7:0]  : wrData[15:8];

  always_comb begin
    txNext = txBuf;
    if (strobe.txHalf)
      txNext = (txBuf << 16) | BUF_W'({firstByte, secondByte});
    else if (strobe.txByte)
      txNext = (txBuf << 8) | BUF_W'(wrData[7:0]);
  end

  always_comb begin
    rxNext = rxBuf;
    if (strobe.rxClear)      rxNext = '0;
    else if (strobe.rxDrop2) rxNext = rxBuf >> 16;
    if (strobe.rxPut) begin
      for (int k = 0; k < DEPTH; k++)
        if (rxPutPos == LEN_W'(k)) rxNext[k*8 +: 8] = rxByte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txBuf <= '0;
      rxBuf <= '0;
    end else begin
      txBuf <= txNext;
      rxBuf <= rxNext;
    end
  end

  // oldest transmit byte sits at the top of the occupied region
  always_comb begin
    txByteOut = '0;
    for (int k = 0; k < DEPTH; k++)
      if (txLen == LEN_W'(k + 1)) txByteOut = txBuf[k*8 +: 8];
  end

  // bytes above the receive count are always zero
  assign rdOld  = rxBuf[7:0];
  assign rdNew  = rxBuf[15:8];
  assign rdData = bigEndian ? {rdOld, rdNew} : {rdNew, rdOld};

  // R8: an empty receive buffer reads as zero
  a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rxLen == '0) |-> (rdData == 16'h0000));

  // R5: an empty transmit queue presents zero to the engine
  a_r5_empty_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (txLen == '0) |-> (txByteOut == 8'h00));

  // R2: transmit storage only moves on an accepted host write
  a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.txHalf && !strobe.txByte) |=> $stable(txBuf));

endmodule

// File: rtl/byte_order_packer.sv
module byte_order_packer
  import packer_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bigEndian,
  input  logic              hostWrHalf,
  input  logic              hostWrByte,
  input  logic [15:0]       hostWrData,
  input  logic              hostRd,
  output logic [15:0]       hostRdData,
  input  logic              engTxTake,
  output logic [7:0]        engTxByte,
  input  logic              engRxValid,
  input  logic [7:0]        engRxByte,
  input  logic [FLAG_W-1:0] flagClear,
  output logic [FLAG_W-1:0] flags,
  output logic [LEN_W-1:0]  txLen,
  output logic [LEN_W-1:0]  rxLen
);

  packer_strobe_t   strobe;
  logic [LEN_W-1:0] rxPutPos;

  packer_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hostWrHalf (hostWrHalf),
    .hostWrByte (hostWrByte),
    .hostRd     (hostRd),
    .engTxTake  (engTxTake),
    .engRxValid (engRxValid),
    .flagClear  (flagClear),
    .strobe     (strobe),
    .rxPutPos   (rxPutPos),
    .txLen      (txLen),
    .rxLen      (rxLen),
    .flags      (flags)
  );

  packer_data #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .bigEndian (bigEndian),
    .wrData    (hostWrData),
    .txLen     (txLen),
    .rxLen     (rxLen),
    .rxPutPos  (rxPutPos),
    .rxByte    (engRxByte),
    .txByteOut (engTxByte),
    .rdData    (hostRdData)
  );

endmodule

// File: tb/sim_byte_order_packer.sv
`timescale 1ns/1ps
module sim_byte_order_packer;

  localparam int DEPTH = 4;
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bigEndian = 1'b0, hostWrHalf = 1'b0, hostWrByte = 1'b0, hostRd = 1'b0;
  logic engTxTake = 1'b0, engRxValid = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [7:0]  engRxByte = '0;
  logic [4:0]  flagClear = '0;
  logic [15:0] hostRdData;
  logic [7:0]  engTxByte;
  logic [4:0]  flags;
  logic [LEN_W-1:0] txLen, rxLen;

  int checks = 0;
  int fails = 0;

  logic [7:0] mTx [DEPTH];
  logic [7:0] mRx [DEPTH];
  int mTxN = 0, mRxN = 0;
  logic [4:0] mFlags = '0;

  always #4 clk = ~clk;

  byte_order_packer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bigEndian(bigEndian),
    .hostWrHalf(hostWrHalf), .hostWrByte(hostWrByte), .hostWrData(hostWrData),
    .hostRd(hostRd), .hostRdData(hostRdData),
    .engTxTake(engTxTake), .engTxByte(engTxByte),
    .engRxValid(engRxValid), .engRxByte(engRxByte),
    .flagClear(flagClear), .flags(flags), .txLen(txLen), .rxLen(rxLen)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expRd(input logic be);
    logic [7:0] o, n;
    o = (mRxN > 0) ? mRx[0] : 8'h00;
    n = (mRxN > 1) ? mRx[1] : 8'h00;
    return be ? {o, n} : {n, o};
  endfunction

  function automatic logic [7:0] expTx();
    return (mTxN > 0) ? mTx[0] : 8'h00;
  endfunction

  task automatic txPush(input logic [7:0] b);
    mTx[mTxN] = b;
    mTxN++;
  endtask

  task automatic txPop();
    for (int k = 0; k < DEPTH - 1; k++) mTx[k] = mTx[k + 1];
    mTxN--;
  endtask

  task automatic rxPop();
    for (int k = 0; k < DEPTH - 1; k++) mRx[k] = mRx[k + 1];
    mRxN--;
  endtask

  task automatic modelAdvance(input logic be, hw, bw, input logic [15:0] wd,
                              input logic rd, take, rxv, input logic [7:0] rxb,
                              input logic [4:0] clr);
    logic [4:0] nf;
    nf = mFlags & ~clr;
    if (take) begin
      if (mTxN == 0) nf[4] = 1'b1;
      else txPop();
      if (mTxN <= DEPTH - 2) nf[0] = 1'b1;
    end
    if ((hw || bw) && mTxN <= DEPTH - 2) begin
      if (hw) begin
        txPush(be ? wd[15:8] : wd[7:0]);
        txPush(be ? wd[7:0] : wd[15:8]);
      end else begin
        txPush(wd[7:0]);
      end
      nf[4] = 1'b0;
      if (mTxN > DEPTH - 2) nf[0] = 1'b0;
    end
    if (rd && mRxN > 0) begin
      nf[3] = 1'b0;
      if (mRxN == 1) begin
        nf[2] = 1'b1;
        mRxN = 0;
      end else begin
        rxPop();
        rxPop();
      end
      if (mRxN == 0) nf[1] = 1'b0;
    end
    if (rxv) begin
      if (mRxN < DEPTH) begin
        mRx[mRxN] = rxb;
        mRxN++;
        nf[1] = 1'b1;
      end else begin
        nf[3] = 1'b1;
      end
    end
    mFlags = nf;
  endtask

  task automatic step(input logic be, hw, bw, input logic [15:0] wd,
                      input logic rd, take, rxv, input logic [7:0] rxb,
                      input logic [4:0] clr,
                      output logic [15:0] rdSeen, output logic [7:0] txSeen);
    @(negedge clk);
    bigEndian = be; hostWrHalf = hw; hostWrByte = bw; hostWrData = wd;
    hostRd = rd; engTxTake = take; engRxValid = rxv; engRxByte = rxb; flagClear = clr;
    #1;
    rdSeen = hostRdData;
    txSeen = engTxByte;
    check("R5 oldest transmit byte", {8'h00, txSeen}, {8'h00, expTx()});
    check("R8 host read data", rdSeen, expRd(be));
    modelAdvance(be, hw, bw, wd, rd, take, rxv, rxb, clr);
    @(posedge clk);
    #1;
    check("R2 transmit count", 16'(txLen), 16'(mTxN));
    check("R7 receive count", 16'(rxLen), 16'(mRxN));
    check("R6 transmit ready", 16'(flags[0]), 16'(mFlags[0]));
    check("R10 receive ready", 16'(flags[1]), 16'(mFlags[1]));
    check("R9 single byte", 16'(flags[2]), 16'(mFlags[2]));
    check("R7 overrun", 16'(flags[3]), 16'(mFlags[3]));
    check("R5 underflow", 16'(flags[4]), 16'(mFlags[4]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rdS;
    logic [7:0]  txS;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 reset txLen", 16'(txLen), 16'h0);
    check("R1 reset rxLen", 16'(rxLen), 16'h0);
    check("R1 reset flags", 16'(flags), 16'h0);
    check("R1 reset engTxByte", 16'(engTxByte), 16'h0);
    check("R1 reset hostRdData", hostRdData, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: big-endian halfword sends its upper byte first
    step(1, 1, 0, 16'hA1B2, 0, 0, 0, 8'h00, 5'h0, rdS, txS);
    check("R3 big-endian first byte", 16'(engTxByte), 16'h00A1);
    // R3: little-endian halfword sends its lower byte first (queued behind)
    step(0, 1, 0, 16'hC3D4, 0, 0, 0, 8'h00, 5'h0, rdS, txS);
    check("R2 full after two halfwords", 16'(txLen), 16'd4);
    // R4: byte write into a full queue is refused
    step(0, 0, 1, 16'h0055, 0, 0, 0, 8'h00, 5'h0, rdS, txS);
    check("R4 byte write refused", 16'(txLen), 16'd4);
    step(0, 0, 0, 16'h0000, 0, 1, 0, 8'h00, 5'h0, rdS, txS);
    check("R3 second byte of big-endian word", 16'(engTxByte), 16'h00B2);
    // R11: fetch then halfword write, checked against post-fetch count
    step(1, 1, 0, 16'h1122, 0, 1, 0, 8'h00, 5'h0, rdS, txS);
    check("R11 fetch before write", 16'(txLen), 16'd4);
    check("R3 little-endian lower byte first", 16'(engTxByte), 16'h00D4);

    // R8 / R9: lone byte read in big-endian order
    step(1, 0, 0, 16'h0000, 0, 0, 1, 8'h10, 5'h0, rdS, txS);
    step(1, 0, 0, 16'h0000, 1, 0, 0, 8'h00, 5'h0, rdS, txS);
    check("R8 lone byte big-endian", rdS, 16'h1000);
    check("R9 single-byte flag", 16'(flags[2]), 16'h1);
    // R11: read before receive in one cycle
    step(0, 0, 0, 16'h0000, 0, 0, 1, 8'h20, 5'h0, rdS, txS);
    step(0, 0, 0, 16'h0000, 0, 0, 1, 8'h30, 5'h0, rdS, txS);
    step(0, 0, 0, 16'h0000, 1, 0, 1, 8'h40, 5'h0, rdS, txS);
    check("R8 little-endian pair", rdS, 16'h3020);
    check("R11 read before receive", 16'(rxLen), 16'd1);
    // R12: clear all flags while a receive sets ready
    step(0, 0, 0, 16'h0000, 0, 0, 1, 8'h50, 5'h1F, rdS, txS);
    check("R12 set wins over clear", 16'(flags[1]), 16'h1);
    check("R12 clear single-byte", 16'(flags[2]), 16'h0);

    for (int n = 0; n < 4000; n++) begin
      logic be, hw, bw, rd, take, rxv;
      logic [4:0] clr;
      be   = 1'($urandom % 2);
      hw   = ($urandom % 4) == 0;
      bw   = ($urandom % 6) == 0;
      rd   = ($urandom % 3) == 0;
      take = ($urandom % 3) == 0;
      rxv  = ($urandom % 3) == 0;
      clr  = (($urandom % 12) == 0) ? 5'($urandom) : 5'h0;
      step(be, hw, bw, 16'($urandom), rd, take, rxv, 8'($urandom), clr, rdS, txS);
    end
    step(0, 0, 0, 16'h0000, 0, 0, 0, 8'h00, 5'h0, rdS, txS);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule